// File: doc/BRIEF.md
# Two-Pass 64-bit Add/Subtract/Compare Unit

This unit adds, subtracts or compares two 64-bit operands using a single 32-bit adder that is used twice. When a start strobe arrives while the unit is idle, it latches both operands and the operation code. The first pass works on the lower words and keeps the carry and a zero indication. The second pass works on the upper words, takes in the saved carry, and writes the result and the N, Z, C and V flags. All four flags describe the full 64-bit value.

The controller is a four-state machine. `ST_IDLE` waits for `start`; the transition *accept* goes to `ST_LOW`. `ST_LOW` runs the lower pass; the transition *carry-over* goes to `ST_HIGH`. `ST_HIGH` runs the upper pass and commits the outputs; the transition *commit* goes to `ST_DONE`. `ST_DONE` raises `done` for one cycle; the transition *release* returns to `ST_IDLE`. The unit asserts `busy` in every state except `ST_IDLE`.

A compare runs the subtract sequence and updates only the flags. This lets software test the full 64-bit ordering without losing a result it computed earlier.

Top module: `mc64_arith`

## Requirements
- R1: With `op` = 2'b00 (add), the result is A + B modulo 2^64. The carry out of the lower words feeds the upper words, and C is the carry out of bit 63.
- R2: With `op` = 2'b01 (subtract), the result is A - B modulo 2^64. The lower pass computes A_lo + ~B_lo + 1, and its carry is the borrow input of the upper pass. C is 1 when no borrow occurs, meaning A >= B unsigned.
- R3: V reports two's-complement overflow of the whole 64-bit operation and is taken only from the upper pass. An overflow in the lower words alone never sets V. For example, comparing 0x00000001_80000000 with 0x00000001_7FFFFFFF gives V = 0.
- R4: With `op` = 2'b10 or 2'b11 (compare), N, Z, C and V are set exactly as a subtract would set them, and `result_lo` and `result_hi` keep their previous values.
- R5: Z is 1 only when both 32-bit halves of the 64-bit value are zero. A zero lower half with a nonzero upper half gives Z = 0.
- R6: N equals bit 63 of the 64-bit value.
- R7: When `start` is accepted at a rising edge, `done` is high for exactly one cycle, beginning after the third rising edge counted from the accepting edge. Result and flags are valid while `done` is high. `busy` is high from the accepting edge until `done` falls.
- R8: A `start` seen while `busy` is high is ignored. The operands and operation in progress are unchanged, and no extra `done` pulse is produced.
- R9: After reset, the result and all flags are zero and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 00 add, 01 subtract, 10/11 compare |
| a_lo | input | 32 | Operand A, lower word |
| a_hi | input | 32 | Operand A, upper word |
| b_lo | input | 32 | Operand B, lower word |
| b_hi | input | 32 | Operand B, upper word |
| result_lo | output | 32 | Result, lower word |
| result_hi | output | 32 | Result, upper word |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero over all 64 bits |
| flag_c | output | 1 | Carry / not-borrow |
| flag_v | output | 1 | Signed overflow over 64 bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The `done` pulse and an ignored `start` can fall in the same cycle, because the unit is still busy in `ST_DONE`. The bench provokes this by holding `start` high from acceptance through the whole done cycle, and it changes the operands after the first cycle. It judges the outcome by three things: the result must match the first operand set, `busy` must drop on the next cycle, and no second `done` may appear.

// File: rtl/mc64_pkg.sv
package mc64_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_CMP  = 2'b10,
        OP_CMPX = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_LOW  = 2'b01,
        ST_HIGH = 2'b10,
        ST_DONE = 2'b11
    } state_e;
endpackage

// File: rtl/mc64_adder.sv
module mc64_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
        // signed overflow: like-signed inputs give a sum of the other sign
        ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/mc64_ctrl.sv
module mc64_ctrl
    import mc64_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic pass_lo,
    output logic pass_hi,
    output logic busy,
    output logic done
);
    state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_LOW;   // accept
            ST_LOW:  state_nx = ST_HIGH;             // carry-over
            ST_HIGH: state_nx = ST_DONE;             // commit
            ST_DONE: state_nx = ST_IDLE;             // release
        endcase
    end

    always_comb begin
        load    = 1'b0;
        pass_lo = 1'b0;
        pass_hi = 1'b0;
        done    = 1'b0;
        busy    = 1'b1;
        unique case (state)
            ST_IDLE: begin busy = 1'b0; load = start; end
            ST_LOW:  pass_lo = 1'b1;
            ST_HIGH: pass_hi = 1'b1;
            ST_DONE: done = 1'b1;
        endcase
    end

    // R7: done appears two cycles after busy rises, and lasts one cycle
    a_r7_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ##2 done);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: start during busy does not disturb the pass sequence
    a_r8_busy_sequence: assert property (@(posedge clk) disable iff (!rst_n)
        pass_lo |=> pass_hi);
endmodule

// File: rtl/mc64_datapath.sv
module mc64_datapath
    import mc64_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              pass_lo,
    input  logic              pass_hi,
    input  logic              done,
    input  logic [1:0]        op,
    input  logic [HALF_W-1:0] a_lo,
    input  logic [HALF_W-1:0] a_hi,
    input  logic [HALF_W-1:0] b_lo,
    input  logic [HALF_W-1:0] b_hi,
    output logic [HALF_W-1:0] res_lo,
    output logic [HALF_W-1:0] res_hi,
    output logic              fl_n,
    output logic              fl_z,
    output logic              fl_c,
    output logic              fl_v
);
    localparam int FULL_W = 2 * HALF_W;

    logic [FULL_W-1:0] a_q, b_q;
    op_e               op_q;
    logic              is_sub, is_cmp;
    logic [HALF_W-1:0] ax, by, sum, lo_sum_q;
    logic              cin, cout, ovf, carry_q, zlo_q;

    always_comb begin
        is_sub = 1'b1;
        is_cmp = 1'b0;
        unique case (op_q)
            OP_ADD:  is_sub = 1'b0;
            OP_SUB:  is_sub = 1'b1;
            OP_CMP,
            OP_CMPX: is_cmp = 1'b1;
        endcase
    end

    // one shared adder; lower words on the first pass, upper on the second
    always_comb begin
        ax  = pass_hi ? a_q[FULL_W-1:HALF_W] : a_q[HALF_W-1:0];
        by  = pass_hi ? b_q[FULL_W-1:HALF_W] : b_q[HALF_W-1:0];
        if (is_sub) by = ~by;
        cin = pass_hi ? carry_q : is_sub;
    end

    mc64_adder #(.W(HALF_W)) u_add (
        .x(ax), .y(by), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            op_q     <= OP_ADD;
            carry_q  <= 1'b0;
            zlo_q    <= 1'b0;
            lo_sum_q <= '0;
            res_lo   <= '0;
            res_hi   <= '0;
            fl_n     <= 1'b0;
            fl_z     <= 1'b0;
            fl_c     <= 1'b0;
            fl_v     <= 1'b0;
        end else begin
            if (load) begin
                a_q  <= {a_hi, a_lo};
                b_q  <= {b_hi, b_lo};
                op_q <= op_e'(op);
            end
            if (pass_lo) begin
                carry_q  <= cout;
                zlo_q    <= (sum == '0);
                lo_sum_q <= sum;
            end
            if (pass_hi) begin
                if (!is_cmp) begin
                    res_lo <= lo_sum_q;
                    res_hi <= sum;
                end
                fl_n <= sum[HALF_W-1];
                fl_z <= zlo_q && (sum == '0);
                fl_c <= cout;
                fl_v <= ovf;
            end
        end
    end

    // R4: a compare leaves the result untouched
    a_r4_cmp_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_hi && is_cmp) |=> ($stable(res_lo) && $stable(res_hi)));
    // R3: flags move only at the upper-pass commit
    a_r3_flags_only_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_hi |=> $stable({fl_n, fl_z, fl_c, fl_v}));
    // R6: for add/sub, N mirrors the top result bit when done
    a_r6_n_is_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_cmp) |-> (fl_n == res_hi[HALF_W-1]));
    // R5: for add/sub, Z agrees with the whole stored result when done
    a_r5_z_both_halves: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_cmp) |-> (fl_z == ((res_lo == '0) && (res_hi == '0))));
    // R8: operands stay frozen while the passes run
    a_r8_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_lo || pass_hi) |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/mc64_arith.sv
module mc64_arith #(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [HALF_W-1:0] a_lo,
    input  logic [HALF_W-1:0] a_hi,
    input  logic [HALF_W-1:0] b_lo,
    input  logic [HALF_W-1:0] b_hi,
    output logic [HALF_W-1:0] result_lo,
    output logic [HALF_W-1:0] result_hi,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic              busy,
    output logic              done
);
    logic load, pass_lo, pass_hi;

    mc64_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load(load), .pass_lo(pass_lo), .pass_hi(pass_hi),
        .busy(busy), .done(done)
    );

    mc64_datapath #(.HALF_W(HALF_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .load(load),
        .pass_lo(pass_lo), .pass_hi(pass_hi), .done(done), .op(op),
        .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
        .res_lo(result_lo), .res_hi(result_hi),
        .fl_n(flag_n), .fl_z(flag_z), .fl_c(flag_c), .fl_v(flag_v)
    );

    // R9: idle after reset until a start is seen
    a_r9_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !done);
endmodule

// File: tb/sim_mc64_arith.sv
module sim_mc64_arith;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
    logic [31:0] result_lo, result_hi;
    logic        flag_n, flag_z, flag_c, flag_v, busy, done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [63:0] prev_res = '0;

    always #10 clk = ~clk;

    mc64_arith u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi),
        .result_lo(result_lo), .result_hi(result_hi),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .busy(busy), .done(done)
    );

    localparam int NV = 10;
    localparam logic [129:0] VEC [NV] = '{
        {2'b00, 64'h00000000_FFFFFFFF, 64'h00000000_00000001},
        {2'b00, 64'h7FFFFFFF_FFFFFFFF, 64'h00000000_00000001},
        {2'b00, 64'hFFFFFFFF_FFFFFFFF, 64'h00000000_00000001},
        {2'b01, 64'h00000001_00000000, 64'h00000000_00000001},
        {2'b01, 64'h00000000_00000005, 64'h00000001_00000000},
        {2'b10, 64'h00000001_80000000, 64'h00000001_7FFFFFFF},
        {2'b01, 64'h80000000_00000000, 64'h00000000_00000001},
        {2'b10, 64'h12345678_9ABCDEF0, 64'h12345678_9ABCDEF0},
        {2'b01, 64'h00000001_00000000, 64'h00000000_00000000},
        {2'b11, 64'h00000000_00000000, 64'h00000000_00000001}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic model(input logic [1:0] o, input logic [63:0] a,
                         input logic [63:0] b, output logic [63:0] r,
                         output logic [3:0] nzcv);
        logic [64:0] w;
        logic v;
        if (o == 2'b00) begin
            w = {1'b0, a} + {1'b0, b};
            v = (a[63] == b[63]) && (w[63] != a[63]);
        end else begin
            w = {1'b0, a} + {1'b0, ~b} + 65'd1;
            v = (a[63] != b[63]) && (w[63] != a[63]);
        end
        r = w[63:0];
        nzcv = {w[63], (w[63:0] == 64'd0), w[64], v};
    endtask

    // issue one op; verify done timing (R7)
    task automatic run(input logic [1:0] o, input logic [63:0] a,
                       input logic [63:0] b);
        @(negedge clk);
        op = o; a_lo = a[31:0]; a_hi = a[63:32]; b_lo = b[31:0]; b_hi = b[63:32];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R7 busy after accept", {62'd0, busy, done}, 64'd2);
        @(negedge clk);
        check(!done, "R7 no early done", {63'd0, done}, 64'd0);
        @(negedge clk);
        check(done, "R7 done on third cycle", {63'd0, done}, 64'd1);
    endtask

    task automatic judge(input logic [1:0] o, input logic [63:0] a,
                         input logic [63:0] b);
        logic [63:0] er;
        logic [3:0]  ef;
        logic [63:0] ar;
        model(o, a, b, er, ef);
        ar = {result_hi, result_lo};
        if (o[1]) begin
            check(ar == prev_res, "R4 compare keeps result", ar, prev_res);
            check({flag_n, flag_z, flag_c, flag_v} == ef, "R4 compare flags",
                  {60'd0, flag_n, flag_z, flag_c, flag_v}, {60'd0, ef});
        end else begin
            check(ar == er, o[0] ? "R2 subtract result" : "R1 add result", ar, er);
            check(flag_c == ef[1], o[0] ? "R2 not-borrow C" : "R1 carry C",
                  {63'd0, flag_c}, {63'd0, ef[1]});
            prev_res = er;
        end
        check(flag_v == ef[0], "R3 V over 64 bits", {63'd0, flag_v}, {63'd0, ef[0]});
        check(flag_z == ef[2], "R5 Z over both halves", {63'd0, flag_z}, {63'd0, ef[2]});
        check(flag_n == ef[3], "R6 N from bit 63", {63'd0, flag_n}, {63'd0, ef[3]});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9: reset state
        check({result_hi, result_lo} == 64'd0, "R9 reset result",
              {result_hi, result_lo}, 64'd0);
        check({flag_n, flag_z, flag_c, flag_v, busy, done} == 6'd0, "R9 reset flags/status",
              {58'd0, flag_n, flag_z, flag_c, flag_v, busy, done}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run(VEC[i][129:128], VEC[i][127:64], VEC[i][63:0]);
            judge(VEC[i][129:128], VEC[i][127:64], VEC[i][63:0]);
        end

        // R3 directed: lower-word overflow only, compare must not set V
        run(2'b10, 64'h00000001_80000000, 64'h00000001_7FFFFFFF);
        check({flag_n, flag_z, flag_c, flag_v} == 4'b0010, "R3 split-overflow compare NZCV",
              {60'd0, flag_n, flag_z, flag_c, flag_v}, 64'h2);

        // R5 directed: zero lower half, nonzero upper half
        run(2'b00, 64'h00000001_00000000, 64'h00000000_00000000);
        check(!flag_z, "R5 upper nonzero gives Z=0", {63'd0, flag_z}, 64'd0);
        prev_res = 64'h00000001_00000000;

        // R8: start held through the whole op, operands swapped while busy
        @(negedge clk);
        op = 2'b00; a_lo = 32'd3; a_hi = 32'd0; b_lo = 32'd4; b_hi = 32'd0;
        start = 1'b1;
        @(negedge clk);
        op = 2'b01; a_lo = 32'hDEAD; a_hi = 32'h1; b_lo = 32'h5; b_hi = 32'h0;
        @(negedge clk);
        @(negedge clk);
        check(done, "R8 done with start held", {63'd0, done}, 64'd1);
        check({result_hi, result_lo} == 64'd7, "R8 busy start ignored",
              {result_hi, result_lo}, 64'd7);
        start = 1'b0;
        @(negedge clk);
        check(!busy && !done, "R8 no extra operation",
              {62'd0, busy, done}, 64'd0);
        @(negedge clk);
        check(!done && {result_hi, result_lo} == 64'd7, "R8 result stays",
              {result_hi, result_lo}, 64'd7);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule